// File: doc/BRIEF.md
# Two-Level Nested Interrupt Arbiter

This block decides which interrupt request a small processor core takes next. Each source has a request line and a level bit that places it in the lower level (0) or the upper level (1). The core supplies the mask field from its status register, a strobe for each decoded instruction, and a strobe for each return-from-interrupt it executes. When a request wins, the block issues a one-cycle take pulse, a one-hot acknowledge to the winning source, and a vector fetch address. The core uses that address in place of its program counter for the next fetch.

On every entry the block pushes the mask the core had onto a small LIFO and raises the mask: a lower-level entry leaves only upper-level requests open, and an upper-level entry closes both levels. A return pops the saved mask back. A spacing counter stops a second entry from following the first until the core has decoded four instructions. The core reloads its status-register mask from `mask_out`, so `mask_out` follows `mask_in` whenever no entry or return occurs.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, `take_irq` is 0, `irq_ack` is 0, `vec_addr` is 0, `stack_err` is 0 and `mask_out` is 2'b00.
- R2: When both levels have eligible requests in the same cycle, the level-1 source wins (`irq_lvl[n]`=1 marks level 1, 0 marks level 0).
- R3: Among eligible requests of the same level, the lowest source index wins. This holds whether the requests arrive together or have been pending together.
- R4: On a take for source n, `vec_addr` = `VEC_BASE` + 2n + 1, which is the second word of a two-word table entry (0x100 + 2n + 1 by default). `vec_addr` keeps that value until the next take.
- R5: A take shows as `take_irq`=1 for exactly one cycle, one clock edge after the cycle in which the request was eligible. In that same cycle `irq_ack` has only bit n set. At all other times `irq_ack` is 0.
- R6: Mask encoding: 2'b00 lets both levels in, 2'b01 lets only level 1 in, and 2'b10 and 2'b11 block both. A level-0 take sets `mask_out` to 2'b01, and a level-1 take sets it to 2'b11.
- R7: Eligibility is judged from `mask_in`. A level-0 request is ignored unless `mask_in`=2'b00, and a level-1 request is ignored while `mask_in[1]`=1.
- R8: After a take, no further take occurs until four `decode_stb` pulses have been sampled, counting from the cycle in which `take_irq` is high.
- R9: `rti_stb` sets `mask_out` to the `mask_in` value saved at the matching entry, in last-in, first-out order across nested entries.
- R10: While `STACK_DEPTH` (default 4) entries are outstanding, no take occurs. A take becomes possible again after a return.
- R11: `rti_stb` with no outstanding entry sets `stack_err`, which stays set until reset. In that case `mask_out` simply follows `mask_in`.
- R12: No take is granted from a cycle in which `rti_stb` is high. A pending request is taken from the following cycle.
- R13: In a cycle with no take and no valid return, `mask_out` takes the value of `mask_in` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_SRC | Level-sensitive request per source |
| irq_lvl | input | N_SRC | Level per source, 1 = level 1 |
| mask_in | input | 2 | Current status-register mask field |
| decode_stb | input | 1 | One pulse per decoded instruction |
| rti_stb | input | 1 | One pulse per executed return-from-interrupt |
| vec_addr | output | ADDR_W | Vector fetch address of the last take |
| take_irq | output | 1 | One-cycle take pulse |
| irq_ack | output | N_SRC | One-hot acknowledge to the winning source |
| mask_out | output | 2 | Mask value for the core to load |
| stack_err | output | 1 | Sticky flag for a return with no outstanding entry |

## Verification
A return and a grant can fall into the same cycle. The bench provokes this by raising an eligible request in exactly the cycle that `rti_stb` pulses, with the spacing counter already at zero and the stack not full. It then judges that `take_irq` stays low at the next edge and rises one edge later with the correct acknowledge. The bench also holds a level-1 request pending while the decode strobes of a level-0 entry are being counted. It confirms that the grant lands exactly one edge after the fourth strobe, and not before.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef logic [1:0] mask_t;
    localparam mask_t MASK_OPEN    = 2'b00;
    localparam mask_t MASK_L1_ONLY = 2'b01;
    localparam mask_t MASK_CLOSED  = 2'b11;

    function automatic logic lvl0_open(input mask_t m);
        return (m == MASK_OPEN);
    endfunction

    function automatic logic lvl1_open(input mask_t m);
        return !m[1];
    endfunction
endpackage

// File: rtl/irq_pick.sv
module irq_pick
    import irq_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] req,
    input  logic [N_SRC-1:0] lvl,
    input  mask_t            mask,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [N_SRC-1:0] onehot,
    output logic             win_lvl
);
    logic [N_SRC-1:0] elig0;
    logic [N_SRC-1:0] elig1;
    logic [N_SRC-1:0] sel;

    for (genvar g = 0; g < N_SRC; g++) begin : g_elig
        assign elig0[g] = req[g] & ~lvl[g] & lvl0_open(mask);
        assign elig1[g] = req[g] &  lvl[g] & lvl1_open(mask);
    end

    always_comb begin
        win_lvl = |elig1;
        sel     = win_lvl ? elig1 : elig0;
        any     = |sel;
        onehot  = sel & (~sel + N_SRC'(1));
        idx     = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (sel[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_mask_stack.sv
module irq_mask_stack
    import irq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  mask_t push_data,
    input  logic  pop,
    output mask_t top_data,
    output logic  full,
    output logic  empty
);
    typedef struct packed {
        mask_t [DEPTH-1:0] slot;
        logic [CNT_W-1:0]  cnt;
    } stk_t;

    stk_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        full     = (st_q.cnt == CNT_W'(DEPTH));
        empty    = (st_q.cnt == '0);
        top_data = MASK_OPEN;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i + 1) == st_q.cnt) top_data = st_q.slot[i];
        end
        if (push && !full) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) == st_q.cnt) st_d.slot[i] = push_data;
            end
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end else if (pop && !empty) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push); // R10
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R11
endmodule

// File: rtl/irq_spacer.sv
module irq_spacer #(
    parameter int GAP = 4,
    localparam int CW = $clog2(GAP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic dec,
    output logic busy
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } sp_t;

    sp_t sp_q, sp_d;

    always_comb begin
        sp_d = sp_q;
        busy = (sp_q.cnt != '0);
        if (load)              sp_d.cnt = CW'(GAP);
        else if (dec && busy)  sp_d.cnt = sp_q.cnt - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sp_q <= '0;
        else        sp_q <= sp_d;
    end

    AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !load); // R8
    AST_HOLD_NO_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !dec) |=> busy); // R8
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import irq_pkg::*;
#(
    parameter int              N_SRC       = 8,
    parameter int              ADDR_W      = 16,
    parameter logic [15:0]     VEC_BASE    = 16'h0100,
    parameter int              STACK_DEPTH = 4,
    parameter int              GAP         = 4,
    localparam int             IDX_W       = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_req,
    input  logic [N_SRC-1:0]  irq_lvl,
    input  logic [1:0]        mask_in,
    input  logic              decode_stb,
    input  logic              rti_stb,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              take_irq,
    output logic [N_SRC-1:0]  irq_ack,
    output logic [1:0]        mask_out,
    output logic              stack_err
);
    typedef struct packed {
        mask_t             mask;
        logic [ADDR_W-1:0] vec;
        logic              take;
        logic [N_SRC-1:0]  ack;
        logic              err;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic             pk_any;
    logic [IDX_W-1:0] pk_idx;
    logic [N_SRC-1:0] pk_onehot;
    logic             pk_lvl;
    logic             sp_busy;
    logic             stk_full;
    logic             stk_empty;
    mask_t            stk_top;
    logic             grant;
    logic             pop_ok;

    irq_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
        .req     (irq_req),
        .lvl     (irq_lvl),
        .mask    (mask_in),
        .any     (pk_any),
        .idx     (pk_idx),
        .onehot  (pk_onehot),
        .win_lvl (pk_lvl)
    );

    irq_spacer #(.GAP(GAP)) u_space (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (grant),
        .dec   (decode_stb),
        .busy  (sp_busy)
    );

    irq_mask_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (grant),
        .push_data (mask_in),
        .pop       (pop_ok),
        .top_data  (stk_top),
        .full      (stk_full),
        .empty     (stk_empty)
    );

    always_comb begin
        grant  = pk_any && !sp_busy && !stk_full && !rti_stb;
        pop_ok = rti_stb && !stk_empty;

        ctl_d      = ctl_q;
        ctl_d.take = grant;
        ctl_d.ack  = grant ? pk_onehot : '0;
        ctl_d.err  = ctl_q.err | (rti_stb && stk_empty);
        if (grant)
            ctl_d.vec = ADDR_W'(VEC_BASE) + ADDR_W'({pk_idx, 1'b1});

        if (grant)       ctl_d.mask = pk_lvl ? MASK_CLOSED : MASK_L1_ONLY;
        else if (pop_ok) ctl_d.mask = stk_top;
        else             ctl_d.mask = mask_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.mask <= MASK_OPEN;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign vec_addr  = ctl_q.vec;
    assign take_irq  = ctl_q.take;
    assign irq_ack   = ctl_q.ack;
    assign mask_out  = ctl_q.mask;
    assign stack_err = ctl_q.err;

    AST_ACK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> ($countones(irq_ack) == 1)); // R5
    AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !take_irq |-> (irq_ack == '0)); // R5
    AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> !take_irq); // R5
    AST_ENTRY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (mask_out != MASK_OPEN)); // R6
    AST_RTI_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        rti_stb |=> !take_irq); // R12
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |=> stack_err); // R11
endmodule

// File: tb/nest_irq_ctrl_tb_top.sv
module nest_irq_ctrl_tb_top;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_req = '0;
    logic [N-1:0] irq_lvl = '0;
    logic [1:0]   mask_in;
    logic         decode_stb = 1'b0;
    logic         rti_stb = 1'b0;
    logic [15:0]  vec_addr;
    logic         take_irq;
    logic [N-1:0] irq_ack;
    logic [1:0]   mask_out;
    logic         stack_err;

    logic         ovr = 1'b0;
    logic [1:0]   sw_mask = 2'b00;
    int           checks = 0;
    int           errors = 0;
    bit           done = 0;

    assign mask_in = ovr ? sw_mask : mask_out;

    always #10 clk = ~clk;

    nest_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_lvl(irq_lvl),
        .mask_in(mask_in), .decode_stb(decode_stb), .rti_stb(rti_stb),
        .vec_addr(vec_addr), .take_irq(take_irq), .irq_ack(irq_ack),
        .mask_out(mask_out), .stack_err(stack_err)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic decodes(input int n);
        decode_stb = 1'b1;
        repeat (n) tick();
        decode_stb = 1'b0;
    endtask

    task automatic do_rti();
        rti_stb = 1'b1;
        tick();
        rti_stb = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 take", take_irq, 0);
        chk("R1 ack", irq_ack, 0);
        chk("R1 vec", vec_addr, 0);
        chk("R1 err", stack_err, 0);
        chk("R1 mask", mask_out, 0);
    endtask

    task automatic t_levels();
        irq_req[2] = 1; irq_lvl[2] = 0;
        irq_req[5] = 1; irq_lvl[5] = 1;
        tick();
        chk("R2 ack", irq_ack, 32'h20);
        chk("R4 vec", vec_addr, 16'h010B);
        chk("R5 take", take_irq, 1);
        chk("R6 mask l1", mask_out, 2'b11);
        irq_req[5] = 0;
        tick();
        chk("R5 pulse", take_irq, 0);
        chk("R5 ack low", irq_ack, 0);
        chk("R4 vec held", vec_addr, 16'h010B);
        decodes(4);
        do_rti();
        chk("R9 restore", mask_out, 2'b00);
        tick();
        chk("R5 take l0", take_irq, 1);
        chk("R4 vec l0", vec_addr, 16'h0105);
        chk("R6 mask l0", mask_out, 2'b01);
        irq_req[2] = 0;
        decodes(4);
        do_rti();
    endtask

    task automatic t_same_level();
        irq_req = 8'b0100_1010; irq_lvl = '0;
        tick();
        chk("R3 lowest", irq_ack, 32'h02);
        chk("R4 vec src1", vec_addr, 16'h0103);
        irq_req[1] = 0;
        decodes(4);
        do_rti();
        tick();
        chk("R3 pending", irq_ack, 32'h08);
        irq_req = '0;
        decodes(4);
        do_rti();
    endtask

    task automatic t_spacing();
        irq_req[0] = 1; irq_lvl[0] = 0;
        tick();
        chk("R8 first", irq_ack, 32'h01);
        irq_req[0] = 0;
        irq_req[4] = 1; irq_lvl[4] = 1;
        decode_stb = 1'b1;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R8 held", take_irq, 0);
        end
        decode_stb = 1'b0;
        tick();
        chk("R8 nest take", take_irq, 1);
        chk("R8 nest ack", irq_ack, 32'h10);
        chk("R4 vec src4", vec_addr, 16'h0109);
        irq_req[4] = 0;
        decodes(4);
        do_rti();
        chk("R9 inner", mask_out, 2'b01);
        do_rti();
        chk("R9 outer", mask_out, 2'b00);
        irq_lvl = '0;
    endtask

    task automatic t_mask_in();
        ovr = 1; sw_mask = 2'b01;
        irq_req[3] = 1; irq_lvl[3] = 0;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R7 l0 masked", take_irq, 0);
        end
        sw_mask = 2'b11;
        irq_req[6] = 1; irq_lvl[6] = 1;
        tick();
        tick();
        chk("R7 all masked", take_irq, 0);
        sw_mask = 2'b01;
        tick();
        chk("R7 l1 open", irq_ack, 32'h40);
        chk("R6 l1 raise", mask_out, 2'b11);
        irq_req[6] = 0;
        decodes(4);
        chk("R7 l0 still", take_irq, 0);
        sw_mask = 2'b00;
        tick();
        chk("R7 l0 open", irq_ack, 32'h08);
        chk("R6 l0 raise", mask_out, 2'b01);
        irq_req[3] = 0;
        decodes(4);
        do_rti();
        do_rti();
        sw_mask = 2'b10;
        tick();
        chk("R13 follow", mask_out, 2'b10);
        sw_mask = 2'b00;
        tick();
        chk("R13 follow2", mask_out, 2'b00);
        ovr = 0;
        irq_lvl = '0;
    endtask

    task automatic t_depth();
        ovr = 1; sw_mask = 2'b00;
        irq_req[7] = 1; irq_lvl[7] = 0;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R10 fill", irq_ack, 32'h80);
            decodes(4);
        end
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R10 full", take_irq, 0);
        end
        do_rti();
        chk("R10 rti cycle", take_irq, 0);
        tick();
        chk("R10 reopen", take_irq, 1);
        irq_req = '0;
        decodes(4);
        repeat (4) do_rti();
        chk("R10 no err", stack_err, 0);
    endtask

    task automatic t_rti_same();
        irq_req[7] = 1;
        tick();
        chk("R12 setup", take_irq, 1);
        irq_req = '0;
        decodes(4);
        irq_req[7] = 1;
        rti_stb = 1'b1;
        tick();
        rti_stb = 1'b0;
        chk("R12 blocked", take_irq, 0);
        tick();
        chk("R12 next", irq_ack, 32'h80);
        irq_req = '0;
        decodes(4);
        do_rti();
        chk("R12 no err", stack_err, 0);
    endtask

    task automatic t_err();
        sw_mask = 2'b01;
        tick();
        chk("R11 pre", stack_err, 0);
        do_rti();
        chk("R11 set", stack_err, 1);
        chk("R11 mask", mask_out, 2'b01);
        tick();
        tick();
        chk("R11 sticky", stack_err, 1);
        ovr = 0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_levels();
        t_same_level();
        t_spacing();
        t_mask_in();
        t_depth();
        t_rti_same();
        t_err();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule